// File: doc/BRIEF.md
# Log-Depth Prefix Carry Adder

This block adds two unsigned operands of a parameter width (16 bits by default) and returns the sum and the carry-out. It is purely combinational: it has no clock, no reset and no internal state. It is meant for paths where a ripple carry chain would be too slow.

The adder works in three stages. The first stage forms a generate bit and a propagate bit for each bit position. The middle stage is a doubling-span prefix network. It merges these pairs into group terms, and every carry is ready after log2(WIDTH) combine levels. The last stage XORs each propagate bit with the group carry from the bits below it, and it forms the carry-out from the top bit. The combine cell maps (g_hi, p_hi) and (g_lo, p_lo) to (g_hi | (p_hi & g_lo), p_hi & p_lo). Because this operator is associative, the network can group terms in any order.

Top module: `prefix_adder`

## Requirements
- R1: Sum bit 0 is a_i[0] XOR b_i[0], because no carry enters bit 0.
- R2: sum_o equals the low WIDTH bits of the unsigned sum a_i + b_i, for every operand pair.
- R3: cout_o equals bit WIDTH of the unsigned sum a_i + b_i. This bit is 1 exactly when the true sum does not fit in WIDTH bits.
- R4: An all-ones operand plus 1 gives sum_o equal to zero and cout_o equal to 1. The carry generated at bit 0 propagates through every position.
- R5: 0 + 0 gives sum_o equal to zero and cout_o equal to 0.
- R6: All-ones plus all-ones gives sum_o equal to all-ones with bit 0 cleared, and cout_o equal to 1.
- R7: When a_i and b_i have no set bit in common, nothing generates a carry. In that case sum_o equals a_i OR b_i and cout_o is 0.
- R8: Swapping the two operands leaves both sum_o and cout_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The block holds no state, so a wrong combine cell, a wrong span or a wrong pass-through shows up at once: the outputs are wrong for the same operands that exercise the fault. A misrouted group term usually corrupts only the sum bits above the faulty position. For that reason the stimulus includes long propagate runs (all-ones plus one) and dense generate patterns (all-ones plus all-ones) as well as random operands. The carry-out is checked separately, because it is formed from the top bit alone.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

endpackage

// File: rtl/pg_precompute.sv
module pg_precompute
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output gp_t  [WIDTH-1:0] leaf_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign leaf_o[i].g = a_i[i] & b_i[i];
    assign leaf_o[i].p = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/prefix_cell.sv
module prefix_cell
  import prefix_adder_pkg::*;
(
  input  gp_t hi_i,
  input  gp_t lo_i,
  output gp_t grp_o
);

  assign grp_o.g = hi_i.g | (hi_i.p & lo_i.g);
  assign grp_o.p = hi_i.p & lo_i.p;

endmodule

// File: rtl/prefix_network.sv
module prefix_network
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  gp_t [WIDTH-1:0] leaf_i,
  output gp_t [WIDTH-1:0] grp_o
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  gp_t [LEVELS:0][WIDTH-1:0] row;

  assign row[0] = leaf_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int SPAN = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      if (i >= SPAN) begin : g_comb
        prefix_cell u_cell (
          .hi_i  (row[k][i]),
          .lo_i  (row[k][i-SPAN]),
          .grp_o (row[k+1][i])
        );
      end else begin : g_pass
        assign row[k+1][i] = row[k][i];
      end
    end
  end

  assign grp_o = row[LEVELS];

endmodule

// File: rtl/sum_post.sv
module sum_post
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  gp_t  [WIDTH-1:0] leaf_i,
  input  gp_t  [WIDTH-1:0] grp_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] carry_in;

  // carry into bit i is the group generate of bits i-1..0
  assign carry_in[0] = 1'b0;
  for (genvar i = 1; i < WIDTH; i++) begin : g_cin
    assign carry_in[i] = grp_i[i-1].g;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = leaf_i[i].p ^ carry_in[i];
  end

  assign cout_o = leaf_i[WIDTH-1].g | (leaf_i[WIDTH-1].p & carry_in[WIDTH-1]);

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  gp_t [WIDTH-1:0] leaf;
  gp_t [WIDTH-1:0] grp;

  pg_precompute #(.WIDTH(WIDTH)) u_pre (
    .a_i    (a_i),
    .b_i    (b_i),
    .leaf_o (leaf)
  );

  prefix_network #(.WIDTH(WIDTH)) u_net (
    .leaf_i (leaf),
    .grp_o  (grp)
  );

  sum_post #(.WIDTH(WIDTH)) u_post (
    .leaf_i (leaf),
    .grp_i  (grp),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_bit0_r1: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
      else $error("R1 bit 0 wrong");
    p_sum_r2: assert (sum_o == ref_sum[WIDTH-1:0])
      else $error("R2 sum wrong");
    p_cout_r3: assert (cout_o == ref_sum[WIDTH])
      else $error("R3 carry-out wrong");
    if ((a_i & b_i) == '0) begin
      p_nogen_r7: assert (sum_o == (a_i | b_i) && !cout_o)
        else $error("R7 carry without generate");
    end
    if (a_i == '0) begin
      p_zero_r5: assert (sum_o == b_i && !cout_o)
        else $error("R5 zero operand changed result");
    end
  end

endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/prefix_adder_bench.sv
module prefix_adder_bench;

  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] a_i = '0;
  logic [WIDTH-1:0] b_i = '0;
  logic [WIDTH-1:0] sum_o;
  logic             cout_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  prefix_adder #(.WIDTH(WIDTH)) u_prefix_adder (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  // behavioural reference using integer arithmetic
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input string tag);
    longint unsigned full;
    longint unsigned exp_sum;
    longint unsigned exp_c;
    @(posedge clk);
    a_i = a;
    b_i = b;
    full    = longint'(a) + longint'(b);
    exp_sum = full & ((64'd1 << WIDTH) - 1);
    exp_c   = (full >> WIDTH) & 64'd1;
    @(negedge clk);
    n_vec++;
    if (longint'(sum_o) != exp_sum || longint'(cout_o) != exp_c) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h got sum=%h cout=%0d expected sum=%h cout=%0d",
               tag, a, b, sum_o, cout_o, exp_sum, exp_c);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [WIDTH-1:0] ones;
    logic [WIDTH-1:0] s1;
    logic             c1;
    ones = '1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    apply('0, '0, "R5 zero plus zero");
    apply(ones, 1, "R4 all-ones plus one");
    apply(1, ones, "R4 one plus all-ones");
    apply(ones, ones, "R6 all-ones plus all-ones");
    apply(16'h8000, 16'h8000, "R3 msb overflow");
    apply(16'h7FFF, 16'h0001, "R2 carry into msb");
    apply(16'hAAAA, 16'h5555, "R7 disjoint bits");
    apply(16'h0F0F, 16'hF0F0, "R7 disjoint nibbles");
    apply(16'h0001, 16'h0000, "R1 bit zero only");
    apply(16'h0001, 16'h0001, "R1 bit zero generate");

    for (int j = 0; j < WIDTH; j++) begin
      apply(ones >> j, 16'h0001 << (WIDTH - 1 - j), "R2 carry run");
    end

    for (int n = 0; n < 2000; n++) begin
      logic [WIDTH-1:0] ra;
      logic [WIDTH-1:0] rb;
      ra = WIDTH'($urandom);
      rb = WIDTH'($urandom);
      if (n % 4 == 0) rb = rb & ~ra;
      apply(ra, rb, "R2 R3 random");
      check_bit(sum_o[0], ra[0] ^ rb[0], "R1 random bit zero");
      s1 = sum_o;
      c1 = cout_o;
      apply(rb, ra, "R8 swapped operands");
      check_bit(sum_o == s1 && cout_o == c1, 1'b1, "R8 swap equality");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule